// File: doc/BRIEF.md
# Single-Clock FIFO with Threshold Flags

A first-in-first-out buffer running on one clock. Words go in through a write request with data and come out through a read request. The block reports full, empty, a used-word count and two threshold flags. The threshold flags give upstream and downstream logic early warning before the buffer runs out of room or runs dry. All status outputs come straight from registers, and the storage is written so that a block RAM can be inferred.

A parameter picks one of two read modes. In normal mode, a read request loads the oldest word into the output register on the next edge. In look-ahead mode, the oldest word already sits on the output, and a read request consumes it and brings the next word forward. Requests that cannot be served are never carried out. A write into a full buffer or a read from an empty one leaves the contents and the count unchanged. When a guard parameter is turned off, such a request also sets a sticky error flag, so that a caller who breaks the handshake is caught. There are two ways to clear the buffer: a synchronous clear and an asynchronous clear.

Top module: `sync_fifo_flags`

## Requirements
- R1: While the synchronous clear `rst` is high at a clock edge, the next state after that edge is `empty`=1, `full`=0, `used`=0 and `err_flag`=0. The threshold flags take their values for an occupancy of zero.
- R2: An accepted write alone raises `used` by one. An accepted read alone lowers it by one. An accepted read and write in the same cycle leave it unchanged. `used` shows the occupancy modulo 2^CNT_W.
- R3: `full` is high exactly when DEPTH words are stored. `empty` is high exactly when no word is stored.
- R4: `almost_full` is high exactly when the occupancy is greater than or equal to AF_LEVEL.
- R5: `almost_empty` is high exactly when the occupancy is strictly less than AE_LEVEL.
- R6: A write request while `full` is high and no read is accepted in the same cycle is ignored. The count and the stored words do not change.
- R7: A read request while `empty` is high is ignored. The count does not change, and in normal mode `rd_data` keeps its value.
- R8: With OVF_GUARD=0, an ignored write sets `err_flag`. With UNF_GUARD=0, an ignored read sets `err_flag`. Once set, `err_flag` stays high until a clear. With a guard set to 1, the matching ignored request leaves `err_flag` low.
- R9: In normal mode (LOOKAHEAD=0), an accepted read places the oldest stored word on `rd_data` after the same clock edge. Without an accepted read, `rd_data` holds its value. Words leave in the order they were written.
- R10: In look-ahead mode (LOOKAHEAD=1), whenever the buffer is not empty, `rd_data` equals the oldest stored word. This includes the cycle right after a write into an empty buffer. An accepted read moves the output to the next word.
- R11: When `full` is high, a simultaneous read and write are both accepted. `full` stays high and the written word joins the queue.
- R12: Raising `aclr` immediately forces `empty`=1, `full`=0, `used`=0, `err_flag`=0 and `rd_data`=0, with no clock edge needed and no minimum pulse width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous clear, active high |
| aclr | input | 1 | Asynchronous clear, active high |
| wr_data | input | DATA_W | Word to store |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request (consume in look-ahead mode) |
| rd_data | output | DATA_W | Read word |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no word |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL |
| almost_empty | output | 1 | Occupancy below AE_LEVEL |
| used | output | CNT_W | Stored word count |
| err_flag | output | 1 | Sticky flag for an ignored request when its guard is off |

## Verification
The bench builds three small configurations with depth 6, which is not a power of two, so pointer wrap is exercised off a binary boundary. The three are normal mode with guards on, look-ahead mode with guards on, and normal mode with guards off. All three receive the same request stream. A sweep starts from every fill level 0 to 6 and applies each of the four read/write request pairs. This separates an accepted request from a refused one at the two edges, and it shows whether the simultaneous pair at full is treated as a free slot. Two long pseudo-random phases, one biased toward writes and one toward reads, move the threshold flags across both levels many times. A synchronous clear and a mid-cycle asynchronous clear are also checked against the arithmetic model.

// File: rtl/fifo_flags_pkg.sv
package fifo_flags_pkg;

  // Per-cycle decision of the control unit: which requests are carried out
  typedef struct packed {
    logic wr_ok;
    logic rd_ok;
  } xfer_t;

  function automatic int ptr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_flags_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 5,
  parameter int AF_LEVEL  = 12,
  parameter int AE_LEVEL  = 4,
  parameter bit OVF_GUARD = 1'b1,
  parameter bit UNF_GUARD = 1'b1,
  localparam int PTR_W    = ptr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aclr,
  input  logic             wr_req,
  input  logic             rd_req,
  output xfer_t            xfer,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] rd_ptr_nxt,
  output logic             full,
  output logic             empty,
  output logic             almost_full,
  output logic             almost_empty,
  output logic [CNT_W-1:0] used,
  output logic             err_flag
);

  localparam int   OCC_W  = CNT_W + 1;
  localparam logic AF_RST = (AF_LEVEL <= 0);
  localparam logic AE_RST = (AE_LEVEL > 0);

  logic [OCC_W-1:0] occ, occ_nxt;
  logic [PTR_W-1:0] wr_ptr_nxt;
  logic             bad_req;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    xfer.rd_ok = rd_req && !empty;
    // a read in the same cycle frees a slot even when full
    xfer.wr_ok = wr_req && (!full || xfer.rd_ok);
    occ_nxt    = occ + OCC_W'(xfer.wr_ok) - OCC_W'(xfer.rd_ok);
    rd_ptr_nxt = xfer.rd_ok ? step(rd_ptr) : rd_ptr;
    wr_ptr_nxt = xfer.wr_ok ? step(wr_ptr) : wr_ptr;
    bad_req    = (!OVF_GUARD && wr_req && !xfer.wr_ok) ||
                 (!UNF_GUARD && rd_req && !xfer.rd_ok);
  end

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      occ          <= '0;
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      full         <= 1'b0;
      empty        <= 1'b1;
      almost_full  <= AF_RST;
      almost_empty <= AE_RST;
      err_flag     <= 1'b0;
    end else if (rst) begin
      occ          <= '0;
      wr_ptr       <= '0;
      rd_ptr       <= '0;
      full         <= 1'b0;
      empty        <= 1'b1;
      almost_full  <= AF_RST;
      almost_empty <= AE_RST;
      err_flag     <= 1'b0;
    end else begin
      occ          <= occ_nxt;
      wr_ptr       <= wr_ptr_nxt;
      rd_ptr       <= rd_ptr_nxt;
      full         <= (occ_nxt == OCC_W'(DEPTH));
      empty        <= (occ_nxt == '0);
      almost_full  <= ($signed({1'b0, occ_nxt}) >= AF_LEVEL);
      almost_empty <= ($signed({1'b0, occ_nxt}) <  AE_LEVEL);
      err_flag     <= err_flag | bad_req;
    end
  end

  assign used = occ[CNT_W-1:0];

endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 16,
  parameter int ADDR_W      = 4,
  parameter bit WRITE_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aclr,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (WRITE_FIRST) begin : g_bypass
      // a read of the slot being written returns the new word
      assign rd_word = (we && (waddr == raddr)) ? wdata : mem[raddr];
    end else begin : g_plain
      assign rd_word = mem[raddr];
    end
  endgenerate

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      rdata <= '0;
    else if (rst)  rdata <= '0;
    else if (re)   rdata <= rd_word;
  end

endmodule

// File: rtl/sync_fifo_flags.sv
module sync_fifo_flags
  import fifo_flags_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 16,
  parameter int CNT_W     = 5,
  parameter int AF_LEVEL  = 12,
  parameter int AE_LEVEL  = 4,
  parameter bit LOOKAHEAD = 1'b0,
  parameter bit OVF_GUARD = 1'b1,
  parameter bit UNF_GUARD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aclr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              almost_full,
  output logic              almost_empty,
  output logic [CNT_W-1:0]  used,
  output logic              err_flag
);

  localparam int PTR_W = ptr_bits(DEPTH);

  xfer_t            xfer;
  logic [PTR_W-1:0] wr_ptr, rd_ptr, rd_ptr_nxt;
  logic             ram_re;
  logic [PTR_W-1:0] ram_raddr;

  fifo_ctrl #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL),
    .OVF_GUARD(OVF_GUARD), .UNF_GUARD(UNF_GUARD)
  ) u_ctrl (
    .clk(clk), .rst(rst), .aclr(aclr), .wr_req(wr_req), .rd_req(rd_req),
    .xfer(xfer), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .rd_ptr_nxt(rd_ptr_nxt),
    .full(full), .empty(empty), .almost_full(almost_full),
    .almost_empty(almost_empty), .used(used), .err_flag(err_flag)
  );

  generate
    if (LOOKAHEAD) begin : g_lookahead
      // keep the output register loaded with the head of the next state
      assign ram_re    = 1'b1;
      assign ram_raddr = rd_ptr_nxt;
    end else begin : g_normal
      assign ram_re    = xfer.rd_ok;
      assign ram_raddr = rd_ptr;
    end
  endgenerate

  fifo_ram #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(PTR_W), .WRITE_FIRST(LOOKAHEAD)
  ) u_ram (
    .clk(clk), .rst(rst), .aclr(aclr), .we(xfer.wr_ok), .waddr(wr_ptr),
    .wdata(wr_data), .re(ram_re), .raddr(ram_raddr), .rdata(rd_data)
  );

endmodule

// File: rtl/sync_fifo_flags_chk.sv
module sync_fifo_flags_chk #(
  parameter int DEPTH    = 16,
  parameter int CNT_W    = 5,
  parameter int AF_LEVEL = 12,
  parameter int AE_LEVEL = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             aclr,
  input logic             wr_req,
  input logic             rd_req,
  input logic             full,
  input logic             empty,
  input logic             almost_full,
  input logic             almost_empty,
  input logic [CNT_W-1:0] used,
  input logic             err_flag
);

  assert_clear_R1: assert property (@(posedge clk) disable iff (aclr)
    rst |=> (empty && !full && used == '0 && !err_flag));

  assert_count_up_R2: assert property (@(posedge clk) disable iff (rst || aclr)
    (wr_req && !rd_req && !full) |=> (used == CNT_W'($past(used) + 1'b1)));

  assert_full_empty_R3: assert property (@(posedge clk) disable iff (rst || aclr)
    !(full && empty));

  assert_almost_full_R4: assert property (@(posedge clk) disable iff (rst || aclr)
    !full |-> (almost_full == ($signed({1'b0, used}) >= AF_LEVEL)));

  assert_almost_empty_R5: assert property (@(posedge clk) disable iff (rst || aclr)
    !full |-> (almost_empty == ($signed({1'b0, used}) < AE_LEVEL)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst || aclr)
    (full && wr_req && !rd_req) |=> (full && $stable(used)));

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst || aclr)
    (empty && rd_req && !wr_req) |=> (empty && used == '0));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst || aclr)
    err_flag |=> err_flag);

  assert_full_rdwr_R11: assert property (@(posedge clk) disable iff (rst || aclr)
    (full && wr_req && rd_req) |=> full);

endmodule

bind sync_fifo_flags sync_fifo_flags_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .AF_LEVEL(AF_LEVEL), .AE_LEVEL(AE_LEVEL)
) u_chk (
  .clk(clk), .rst(rst), .aclr(aclr), .wr_req(wr_req), .rd_req(rd_req),
  .full(full), .empty(empty), .almost_full(almost_full),
  .almost_empty(almost_empty), .used(used), .err_flag(err_flag)
);

// File: tb/sync_fifo_flags_test.sv
module sync_fifo_flags_test;

  localparam int PERIOD = 10;
  localparam int W  = 8;
  localparam int D  = 6;
  localparam int CW = 3;
  localparam int AF = 5;
  localparam int AE = 2;
  localparam int N  = 3;
  // instance 0: normal, guards on; 1: look-ahead, guards on; 2: normal, guards off
  localparam bit LA [N] = '{1'b0, 1'b1, 1'b0};
  localparam bit GD [N] = '{1'b1, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aclr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic wr_req = 1'b0;
  logic rd_req = 1'b0;

  logic [W-1:0]  o_data [N];
  logic [CW-1:0] o_used [N];
  logic o_full [N], o_empty [N], o_af [N], o_ae [N], o_err [N];

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sync_fifo_flags #(.DATA_W(W), .DEPTH(D), .CNT_W(CW), .AF_LEVEL(AF), .AE_LEVEL(AE),
    .LOOKAHEAD(1'b0), .OVF_GUARD(1'b1), .UNF_GUARD(1'b1)) uut (
    .clk(clk), .rst(rst), .aclr(aclr), .wr_data(wr_data), .wr_req(wr_req), .rd_req(rd_req),
    .rd_data(o_data[0]), .full(o_full[0]), .empty(o_empty[0]), .almost_full(o_af[0]),
    .almost_empty(o_ae[0]), .used(o_used[0]), .err_flag(o_err[0]));

  sync_fifo_flags #(.DATA_W(W), .DEPTH(D), .CNT_W(CW), .AF_LEVEL(AF), .AE_LEVEL(AE),
    .LOOKAHEAD(1'b1), .OVF_GUARD(1'b1), .UNF_GUARD(1'b1)) uut_la (
    .clk(clk), .rst(rst), .aclr(aclr), .wr_data(wr_data), .wr_req(wr_req), .rd_req(rd_req),
    .rd_data(o_data[1]), .full(o_full[1]), .empty(o_empty[1]), .almost_full(o_af[1]),
    .almost_empty(o_ae[1]), .used(o_used[1]), .err_flag(o_err[1]));

  sync_fifo_flags #(.DATA_W(W), .DEPTH(D), .CNT_W(CW), .AF_LEVEL(AF), .AE_LEVEL(AE),
    .LOOKAHEAD(1'b0), .OVF_GUARD(1'b0), .UNF_GUARD(1'b0)) uut_ng (
    .clk(clk), .rst(rst), .aclr(aclr), .wr_data(wr_data), .wr_req(wr_req), .rd_req(rd_req),
    .rd_data(o_data[2]), .full(o_full[2]), .empty(o_empty[2]), .almost_full(o_af[2]),
    .almost_empty(o_ae[2]), .used(o_used[2]), .err_flag(o_err[2]));

  // arithmetic model, one per instance
  logic [W-1:0] mq [N][D];
  int           mc [N];
  bit           me [N];
  logic [W-1:0] mo [N];

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      mc[i] = 0; me[i] = 1'b0; mo[i] = '0;
    end
  endtask

  always @(posedge clk) begin
    if (aclr || rst) begin
      model_clear();
    end else begin
      for (int i = 0; i < N; i++) begin
        bit rok, wok;
        rok = rd_req && (mc[i] > 0);
        wok = wr_req && ((mc[i] < D) || rok);
        if (!GD[i] && ((wr_req && !wok) || (rd_req && !rok))) me[i] = 1'b1;
        if (rok) begin
          mo[i] = mq[i][0];
          for (int k = 0; k < D - 1; k++) mq[i][k] = mq[i][k+1];
          mc[i] = mc[i] - 1;
        end
        if (wok) begin
          mq[i][mc[i]] = wr_data;
          mc[i] = mc[i] + 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string ctx, input int inst,
                     input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s (%s, instance %0d): actual %0d expected %0d",
               req, ctx, inst, got, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    for (int i = 0; i < N; i++) begin
      chk("R2", ctx, i, int'(o_used[i]), mc[i] % (1 << CW));
      chk("R3", ctx, i, int'(o_full[i]), int'(mc[i] == D));
      chk("R3", ctx, i, int'(o_empty[i]), int'(mc[i] == 0));
      chk("R4", ctx, i, int'(o_af[i]), int'(mc[i] >= AF));
      chk("R5", ctx, i, int'(o_ae[i]), int'(mc[i] < AE));
      chk("R8", ctx, i, int'(o_err[i]), int'(me[i]));
      if (!LA[i]) chk("R9", ctx, i, int'(o_data[i]), int'(mo[i]));
      else if (mc[i] > 0) chk("R10", ctx, i, int'(o_data[i]), int'(mq[i][0]));
    end
  endtask

  logic [W-1:0] next_word = 8'h11;

  // drive one cycle of requests, then check after the edge
  task automatic step(input bit w, input bit r, input string ctx);
    wr_req  = w;
    rd_req  = r;
    wr_data = next_word;
    next_word = next_word * 8'd5 + 8'd3;
    @(negedge clk);
    check_all(ctx);
  endtask

  task automatic sync_clear();
    rst = 1'b1; wr_req = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 sync clear");
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_clear();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset state");

    // sweep: every fill level and every request pair
    for (int lvl = 0; lvl <= D; lvl++) begin
      for (int pr = 0; pr < 4; pr++) begin
        string ctx;
        sync_clear();
        for (int k = 0; k < lvl; k++) step(1'b1, 1'b0, "fill");
        if (lvl == D && pr == 1)      ctx = "R6 write when full";
        else if (lvl == 0 && pr == 2) ctx = "R7 read when empty";
        else if (lvl == D && pr == 3) ctx = "R11 read+write when full";
        else                          ctx = "sweep";
        step(pr[0], pr[1], ctx);
        step(1'b0, 1'b0, "idle hold");
        for (int k = 0; k < D + 1; k++) step(1'b0, 1'b1, "drain order");
      end
    end

    // write-biased then read-biased pseudo-random traffic
    lfsr = 16'hACE1;
    for (int c = 0; c < 800; c++) begin
      bit w, r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (c < 400) begin w = lfsr[0] | lfsr[3]; r = lfsr[5] & lfsr[7]; end
      else         begin w = lfsr[0] & lfsr[3]; r = lfsr[5] | lfsr[7]; end
      step(w, r, "random");
      if (c == 600) sync_clear();
    end

    // asynchronous clear mid-cycle, no edge in between
    sync_clear();
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, "fill");
    step(1'b0, 1'b1, "read one");
    wr_req = 1'b0; rd_req = 1'b0;
    #(PERIOD/4);
    aclr = 1'b1;
    model_clear();
    #1;
    check_all("R12 async clear");
    for (int i = 0; i < N; i++) chk("R12", "rd_data cleared", i, int'(o_data[i]), 0);
    aclr = 1'b0;
    @(negedge clk);
    check_all("R12 after release");
    step(1'b1, 1'b0, "R10 write after clear");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule